// File: doc/BRIEF.md
# Iterative Integer Divide Unit

This unit computes a 32-bit quotient for the signed and unsigned integer divide instructions of a small processor core. The issue stage pulses `start` with two operands, a signedness select and the index of the destination register. The unit returns the quotient together with a one-cycle `done` strobe and a write enable for the register file. While an operation is in flight, `busy` is high.

Signed results truncate toward zero. The unit works on operand magnitudes and negates the quotient when the operand signs differ. The unit never raises an exception and never produces an undefined value. Two inputs are handled as special cases: a zero divisor, and the signed overflow pair (the most negative value divided by minus one). In both cases the divisor is treated as one, so the quotient equals the dividend. These special cases are detected when `start` is accepted and finish at once. All other operations run a restoring shift-subtract loop that retires one quotient bit per clock.

Top module: `idiv_unit`

## Requirements
- R1: With `is_signed`=0, `quotient` is the unsigned floor of `dividend`/`divisor` for every nonzero divisor.
- R2: With `is_signed`=1, the operands are read as two's complement and `quotient` is the signed quotient truncated toward zero, for all four sign combinations.
- R3: With `is_signed`=0 and `divisor`=0, `quotient` equals `dividend`.
- R4: With `is_signed`=1 and `divisor`=0, `quotient` equals `dividend`.
- R5: With `is_signed`=1, `dividend`=0x80000000 and `divisor`=0xFFFFFFFF, `quotient` is 0x80000000.
- R6: For the cases of R3 to R5, `done` is high directly after the clock edge that accepts `start`. For every other operation, `busy` is high after that edge, and `done` rises exactly 32 edges later, with `busy` low at that point.
- R7: `done` stays high for one cycle only, unless a new operation is accepted in that same cycle. `quotient` holds its value until the next result is produced.
- R8: `wr_en` is high only together with `done`, and only when the destination index is not 0. `wr_idx` carries the destination index that was captured at start.
- R9: A `start` that arrives while `busy` is high is ignored. It changes neither the result nor `wr_idx`, and it does not end the operation early.
- R10: After reset, `busy`, `done` and `wr_en` are low and `quotient` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a divide; accepted only while not busy |
| is_signed | input | 1 | 1 = signed divide, 0 = unsigned divide |
| dividend | input | 32 | Dividend operand |
| divisor | input | 32 | Divisor operand |
| dest_idx | input | 5 | Destination register index |
| busy | output | 1 | Iterative divide in progress |
| done | output | 1 | One-cycle result strobe |
| quotient | output | 32 | Result, held until the next result |
| wr_en | output | 1 | Register write enable (done and destination not 0) |
| wr_idx | output | 5 | Destination index of the current result |

## Verification
A fixed table covers four groups of cases:
- Small and large unsigned pairs, which separate a correct unsigned floor from a signed reading of bit 31.
- All four sign combinations with uneven magnitudes, which separate truncation toward zero from floor rounding.
- The zero-divisor and overflow pairs in both modes, which check the bypass. The overflow pair given as unsigned must run the full loop.
- A zero destination index.

Each case is also timed, so a bypass and a full-length loop cannot be mistaken for each other. Random operands in both modes exercise the loop's borrow decisions widely. A `start` issued mid-operation with a zero divisor shows whether a busy unit accepts new work.

// File: rtl/idiv_pkg.sv
package idiv_pkg;

    typedef enum logic [0:0] {
        DV_IDLE = 1'b0,
        DV_RUN  = 1'b1
    } dv_phase_e;

endpackage

// File: rtl/idiv_prep.sv
// Start-time operand conditioning: magnitudes, result sign, bypass detect.
module idiv_prep #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sgn,
    output logic [W-1:0] mag_a,
    output logic [W-1:0] mag_b,
    output logic         neg,
    output logic         bypass
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    logic a_neg;
    logic b_neg;

    always_comb begin
        a_neg  = sgn & a[W-1];
        b_neg  = sgn & b[W-1];
        mag_a  = a_neg ? (~a + 1'b1) : a;
        mag_b  = b_neg ? (~b + 1'b1) : b;
        neg    = a_neg ^ b_neg;
        bypass = (b == '0) | (sgn & (a == MOST_NEG) & (b == ALL_ONES));
    end
endmodule

// File: rtl/idiv_step.sv
// One restoring shift-subtract iteration.
module idiv_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] dvs_i,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] quo_o
);
    logic [W:0] shifted;
    logic [W:0] trial;

    always_comb begin
        shifted = {rem_i, quo_i[W-1]};
        trial   = shifted - {1'b0, dvs_i};
        if (!trial[W]) begin
            rem_o = trial[W-1:0];
            quo_o = {quo_i[W-2:0], 1'b1};
        end else begin
            rem_o = shifted[W-1:0];
            quo_o = {quo_i[W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/idiv_unit.sv
module idiv_unit
    import idiv_pkg::*;
#(
    parameter int W  = 32,
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          is_signed,
    input  logic [W-1:0]  dividend,
    input  logic [W-1:0]  divisor,
    input  logic [IW-1:0] dest_idx,
    output logic          busy,
    output logic          done,
    output logic [W-1:0]  quotient,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        dv_phase_e     phase;
        logic [CW-1:0] cnt;
        logic [W-1:0]  rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  dvs;
        logic          neg;
        logic [IW-1:0] dest;
        logic          done;
        logic [W-1:0]  res;
        logic          wr;
    } st_t;

    localparam st_t ST_RESET = '{phase: DV_IDLE, default: '0};

    st_t st_d, st_q;

    logic [W-1:0] mag_a, mag_b;
    logic         neg_s, bypass_s;
    logic [W-1:0] step_rem, step_quo;

    idiv_prep #(.W(W)) u_prep (
        .a      (dividend),
        .b      (divisor),
        .sgn    (is_signed),
        .mag_a  (mag_a),
        .mag_b  (mag_b),
        .neg    (neg_s),
        .bypass (bypass_s)
    );

    idiv_step #(.W(W)) u_step (
        .rem_i (st_q.rem),
        .quo_i (st_q.quo),
        .dvs_i (st_q.dvs),
        .rem_o (step_rem),
        .quo_o (step_quo)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.wr   = 1'b0;
        case (st_q.phase)
            DV_IDLE: begin
                if (start) begin
                    st_d.dest = dest_idx;
                    if (bypass_s) begin
                        st_d.done = 1'b1;
                        st_d.res  = dividend;
                        st_d.wr   = (dest_idx != '0);
                    end else begin
                        st_d.phase = DV_RUN;
                        st_d.cnt   = CW'(W);
                        st_d.rem   = '0;
                        st_d.quo   = mag_a;
                        st_d.dvs   = mag_b;
                        st_d.neg   = neg_s;
                    end
                end
            end
            DV_RUN: begin
                st_d.rem = step_rem;
                st_d.quo = step_quo;
                st_d.cnt = st_q.cnt - 1'b1;
                if (st_q.cnt == CW'(1)) begin
                    st_d.phase = DV_IDLE;
                    st_d.done  = 1'b1;
                    st_d.res   = st_q.neg ? (~step_quo + 1'b1) : step_quo;
                    st_d.wr    = (st_q.dest != '0);
                end
            end
            default: st_d = ST_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    assign busy     = (st_q.phase == DV_RUN);
    assign done     = st_q.done;
    assign quotient = st_q.res;
    assign wr_en    = st_q.wr;
    assign wr_idx   = st_q.dest;

    AST_ZERO_DIV_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && divisor == '0) |=> (done && quotient == $past(dividend))); // R4
    AST_OVF_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && is_signed && dividend == {1'b1, {(W-1){1'b0}}} && divisor == {W{1'b1}})
        |=> (done && quotient == {1'b1, {(W-1){1'b0}}})); // R5
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R6
    AST_DONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done || $past(start))); // R7
    AST_NO_WRITE_R0: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_idx == '0) |-> !wr_en); // R8
    AST_BUSY_HOLDS_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(wr_idx)); // R9
endmodule

// File: tb/test_idiv_unit.sv
`timescale 1ns/1ps
module test_idiv_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        is_signed = 1'b0;
    logic [31:0] dividend = '0;
    logic [31:0] divisor = '0;
    logic [4:0]  dest_idx = '0;
    logic        busy, done, wr_en;
    logic [31:0] quotient;
    logic [4:0]  wr_idx;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    idiv_unit i_idiv_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
        .dividend(dividend), .divisor(divisor), .dest_idx(dest_idx),
        .busy(busy), .done(done), .quotient(quotient),
        .wr_en(wr_en), .wr_idx(wr_idx)
    );

    localparam int NV = 14;
    localparam logic [31:0] VA [NV] = '{
        32'd100, 32'hFFFF_FFFF, 32'd7, 32'hFFFF_FFF9, 32'd7, 32'hFFFF_FFF9,
        32'h1234_5678, 32'h1234_5678, 32'h8000_0000, 32'h8000_0000,
        32'd0, 32'h8000_0000, 32'd5, 32'd3};
    localparam logic [31:0] VB [NV] = '{
        32'd7, 32'd3, 32'hFFFF_FFFE, 32'd2, 32'd2, 32'hFFFF_FFFE,
        32'd0, 32'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
        32'd9, 32'd1, 32'd5, 32'd10};
    localparam logic VS [NV] = '{
        1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1,
        1'b0, 1'b1, 1'b1, 1'b0,
        1'b1, 1'b1, 1'b0, 1'b1};
    localparam logic [4:0] VD [NV] = '{
        5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6,
        5'd7, 5'd8, 5'd9, 5'd0,
        5'd31, 5'd10, 5'd11, 5'd12};

    function automatic logic [31:0] ref_q(logic [31:0] a, logic [31:0] b, logic s);
        if (b == 0) return a;
        if (s && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return a;
        if (s) return 32'($signed(a) / $signed(b));
        return a / b;
    endfunction

    function automatic bit is_fast(logic [31:0] a, logic [31:0] b, logic s);
        return (b == 0) || (s && a == 32'h8000_0000 && b == 32'hFFFF_FFFF);
    endfunction

    function automatic string tag_for(logic [31:0] a, logic [31:0] b, logic s);
        if (b == 0) return s ? "R4" : "R3";
        if (s && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return "R5";
        return s ? "R2" : "R1";
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Issue one divide and check result, latency, write port and strobe width.
    task automatic run_div(logic [31:0] a, logic [31:0] b, logic s, logic [4:0] d);
        int n;
        logic [31:0] exp_q;
        int exp_lat;
        exp_q = ref_q(a, b, s);
        exp_lat = is_fast(a, b, s) ? 0 : 32;
        @(negedge clk);
        start = 1'b1; is_signed = s; dividend = a; divisor = b; dest_idx = d;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0; dividend = $urandom; divisor = $urandom;
        n = 0;
        if (exp_lat != 0) check(busy == 1'b1, "R6", "busy after accept", busy, 1);
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
        end
        check(n == exp_lat, "R6", "latency", n, exp_lat);
        check(quotient == exp_q, tag_for(a, b, s), "quotient", quotient, exp_q);
        check(wr_en == (d != 0), "R8", "wr_en", wr_en, d != 0);
        check(wr_idx == d, "R8", "wr_idx", wr_idx, d);
        check(busy == 1'b0, "R6", "busy at done", busy, 0);
        @(negedge clk);
        check(done == 1'b0, "R7", "done one cycle", done, 0);
        check(quotient == exp_q, "R7", "quotient held", quotient, exp_q);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(busy == 0, "R10", "busy in reset", busy, 0);
        check(done == 0, "R10", "done in reset", done, 0);
        check(wr_en == 0, "R10", "wr_en in reset", wr_en, 0);
        check(quotient == 0, "R10", "quotient in reset", quotient, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && done == 0, "R10", "idle after reset", {busy, done}, 0);

        for (int i = 0; i < NV; i++) run_div(VA[i], VB[i], VS[i], VD[i]);

        // Random operands, both modes, all sign mixes
        for (int i = 0; i < 40; i++) begin
            logic [31:0] a, b;
            a = $urandom;
            b = (i % 4 == 0) ? ($urandom >> (i % 31)) : $urandom;
            if (b == 0) b = 32'd13;
            run_div(a, b, i[0], 5'(i + 1));
        end

        // R9: start while busy is ignored
        begin
            int n;
            @(negedge clk);
            start = 1; is_signed = 0; dividend = 32'd1000; divisor = 32'd10; dest_idx = 5'd3;
            @(posedge clk); @(negedge clk);
            start = 0;
            repeat (4) @(negedge clk);
            start = 1; dividend = 32'hDEAD_BEEF; divisor = 32'd0; dest_idx = 5'd9;
            @(posedge clk); @(negedge clk);
            start = 0;
            check(done == 0, "R9", "no early done", done, 0);
            check(wr_idx == 5'd3, "R9", "dest unchanged", wr_idx, 3);
            n = 5;
            while (!done && n < 40) begin
                @(negedge clk);
                n++;
            end
            check(n == 32, "R9", "original latency", n, 32);
            check(quotient == 32'd100, "R9", "original result", quotient, 100);
            check(wr_idx == 5'd3, "R9", "original dest", wr_idx, 3);
            @(negedge clk);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        finished = 1;
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule